// File: doc/BRIEF.md
# Bisync Receive Control Character Classifier

This block sits on the receive path of a byte-oriented binary synchronous link, right after the character assembler. Each character that arrives with a valid strobe is classified one cycle later. The block names the link-control character it carries, or marks it as plain data or as part of the block check field. It also flags whether the character must be counted in the block check, and whether it should be dropped from the data stream.

The block follows the framing of each message. A message starts at the first start-of-header or start-of-text character. Inside it, the block tracks ordinary text and transparent text. Transparent text is entered with a DLE escape, and in it control codes only count when a DLE comes before them. The message ends at an end-of-text, end-of-block or intermediate-block character, and the two check characters that follow are flagged so that a downstream check engine knows where the received check field lies.

The code set, ASCII or EBCDIC, is chosen with a static input. Change it only while reset is held.

Top module: `bsc_ctrl_detect`

## Requirements
- R1: While reset is high, and in the cycle after it falls, every output strobe, the class code and the character output are zero.
- R2: Class codes are data 0, SOH 1, STX 2, ETX 3, EOT 4, ENQ 5, DLE 6, SYN 7, ETB 8, ITB 9 and check field 10. With the code-set select low, the ASCII values are SOH 01, STX 02, ETX 03, EOT 04, ENQ 05, DLE 10, SYN 16, ETB 17 and ITB 1F (hex). With the select high, the EBCDIC values are SOH 01, STX 02, ETX 03, DLE 10, ITB 1F, ETB 26, ENQ 2D, SYN 32 and EOT 37. Any other value is data.
- R3: Each character strobed in is reported with its value and a valid pulse exactly one clock later. No valid pulse appears in cycles without input.
- R4: Outside a message, no character is counted in the check. An SOH or an STX raises the frame-start strobe and is itself excluded from the check.
- R5: In non-transparent text, every character is counted except SYN, which is discarded and excluded.
- R6: A DLE followed by STX enters transparent text. The transparent flag is high from that STX through the character that ends the block, and low for the check field.
- R7: In transparent text, a lone DLE is discarded and excluded. The character after it is taken as data (class 0) and counted, unless it is SYN, ETX, ETB or ITB. Undelimited control values are data and are counted.
- R8: In transparent text, a DLE followed by SYN has both characters discarded and excluded from the check. The SYN is reported as class 7.
- R9: ETX, ETB or ITB in non-transparent text, or one of them following a DLE in transparent text, is counted in the check, raises the frame-end strobe and leaves transparent text.
- R10: The two characters after a block end are reported as class 10 with the check-field strobe, excluded from the check. The block then returns to waiting for a message.
- R11: In non-transparent text, a DLE is excluded from the check. If the next character is STX, that STX is excluded and transparent text begins; otherwise the next character is handled as ordinary text.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ebcdic_sel | input | 1 | Static code-set select: 0 ASCII, 1 EBCDIC |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| o_valid | output | 1 | Classified character valid |
| o_char | output | 8 | Character echoed with its classification |
| o_class | output | 4 | Class code |
| o_crc_en | output | 1 | Count this character in the block check |
| o_discard | output | 1 | Drop this character from the data stream |
| o_frame_start | output | 1 | Message start character |
| o_frame_end | output | 1 | Block-ending character |
| o_check | output | 1 | Character belongs to the received check field |
| o_transparent | output | 1 | Character belongs to transparent text |

## Verification
A wrong framing state shows at the ports on the next character reported after the fault. A lost escape flag turns the character after a DLE into data, so DLE-SYN and DLE-ETX sequences become counted data and the frame-end strobe is missing. A stuck text state makes idle characters count in the check. A bad check-field counter puts class 10 on one character too few or too many. The directed sequences therefore follow every escape and block-end with at least one more character and compare its flags.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int CHAR_W  = 8;
  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_DATA = 4'd0,
    CL_SOH  = 4'd1,
    CL_STX  = 4'd2,
    CL_ETX  = 4'd3,
    CL_EOT  = 4'd4,
    CL_ENQ  = 4'd5,
    CL_DLE  = 4'd6,
    CL_SYN  = 4'd7,
    CL_ETB  = 4'd8,
    CL_ITB  = 4'd9,
    CL_BCC  = 4'd10
  } cls_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_TEXT   = 2'd1,
    S_TRANSP = 2'd2,
    S_BCC    = 2'd3
  } fstate_e;

  typedef struct packed {
    cls_e cls;
    logic crc;
    logic disc;
    logic start;
    logic fin;
    logic chk;
    logic trans;
  } verdict_t;

  function automatic logic is_ender(cls_e c);
    return (c == CL_ETX) || (c == CL_ETB) || (c == CL_ITB);
  endfunction
endpackage

// File: rtl/bsc_char_decode.sv
module bsc_char_decode
  import bsc_pkg::*;
(
  input  logic [CHAR_W-1:0] ch,
  input  logic              ebcdic,
  output cls_e              cls
);
  cls_e cls_a, cls_e_set;

  always_comb begin
    unique case (ch)
      8'h01:   cls_a = CL_SOH;
      8'h02:   cls_a = CL_STX;
      8'h03:   cls_a = CL_ETX;
      8'h04:   cls_a = CL_EOT;
      8'h05:   cls_a = CL_ENQ;
      8'h10:   cls_a = CL_DLE;
      8'h16:   cls_a = CL_SYN;
      8'h17:   cls_a = CL_ETB;
      8'h1F:   cls_a = CL_ITB;
      default: cls_a = CL_DATA;
    endcase
  end

  always_comb begin
    unique case (ch)
      8'h01:   cls_e_set = CL_SOH;
      8'h02:   cls_e_set = CL_STX;
      8'h03:   cls_e_set = CL_ETX;
      8'h10:   cls_e_set = CL_DLE;
      8'h1F:   cls_e_set = CL_ITB;
      8'h26:   cls_e_set = CL_ETB;
      8'h2D:   cls_e_set = CL_ENQ;
      8'h32:   cls_e_set = CL_SYN;
      8'h37:   cls_e_set = CL_EOT;
      default: cls_e_set = CL_DATA;
    endcase
  end

  assign cls = ebcdic ? cls_e_set : cls_a;
endmodule

// File: rtl/bsc_frame_fsm.sv
module bsc_frame_fsm
  import bsc_pkg::*;
#(
  parameter int BCC_LEN = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  cls_e     in_cls,
  output verdict_t vd
);
  localparam int CNT_W = (BCC_LEN < 2) ? 1 : $clog2(BCC_LEN + 1);

  fstate_e          state, nstate;
  logic             pend, npend;
  logic [CNT_W-1:0] cnt, ncnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      pend  <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= nstate;
      pend  <= npend;
      cnt   <= ncnt;
    end
  end

  always_comb begin
    nstate = state;
    npend  = pend;
    ncnt   = cnt;
    vd     = '0;
    vd.cls = CL_DATA;
    if (in_valid) begin
      unique case (state)
        S_IDLE: begin
          vd.cls = in_cls;
          npend  = (in_cls == CL_DLE);
          if (in_cls == CL_SOH || in_cls == CL_STX) begin
            vd.start = 1'b1;
            if (pend && in_cls == CL_STX) begin
              nstate   = S_TRANSP;
              vd.trans = 1'b1;
            end else begin
              nstate = S_TEXT;
            end
          end
        end
        S_TEXT: begin
          vd.cls = in_cls;
          npend  = 1'b0;
          if (pend && in_cls == CL_STX) begin
            nstate   = S_TRANSP;
            vd.trans = 1'b1;
          end else if (in_cls == CL_SYN) begin
            vd.disc = 1'b1;
          end else if (in_cls == CL_DLE) begin
            npend = 1'b1;
          end else if (is_ender(in_cls)) begin
            vd.crc = 1'b1;
            vd.fin = 1'b1;
            nstate = S_BCC;
            ncnt   = '0;
          end else begin
            vd.crc = 1'b1;
          end
        end
        S_TRANSP: begin
          vd.trans = 1'b1;
          if (!pend) begin
            if (in_cls == CL_DLE) begin
              npend   = 1'b1;
              vd.cls  = CL_DLE;
              vd.disc = 1'b1;
            end else begin
              vd.crc = 1'b1;
            end
          end else begin
            npend = 1'b0;
            if (in_cls == CL_SYN) begin
              vd.cls  = CL_SYN;
              vd.disc = 1'b1;
            end else if (is_ender(in_cls)) begin
              vd.cls = in_cls;
              vd.crc = 1'b1;
              vd.fin = 1'b1;
              nstate = S_BCC;
              ncnt   = '0;
            end else begin
              vd.crc = 1'b1;
            end
          end
        end
        default: begin
          vd.cls = CL_BCC;
          vd.chk = 1'b1;
          npend  = 1'b0;
          if (cnt == CNT_W'(BCC_LEN - 1)) begin
            nstate = S_IDLE;
            ncnt   = '0;
          end else begin
            ncnt = cnt + 1'b1;
          end
        end
      endcase
    end
  end

  p_bcc_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_BCC) |-> (cnt < CNT_W'(BCC_LEN)));
  p_no_escape_in_bcc_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_BCC) |-> !pend);
  p_bcc_follows_end_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (state == S_TEXT || state == S_TRANSP) && vd.fin) |=> (state == S_BCC));
endmodule

// File: rtl/bsc_ctrl_detect.sv
module bsc_ctrl_detect
  import bsc_pkg::*;
#(
  parameter int BCC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ebcdic_sel,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              o_valid,
  output logic [CHAR_W-1:0] o_char,
  output logic [CLASS_W-1:0] o_class,
  output logic              o_crc_en,
  output logic              o_discard,
  output logic              o_frame_start,
  output logic              o_frame_end,
  output logic              o_check,
  output logic              o_transparent
);
  cls_e     dec_cls;
  verdict_t vd;

  bsc_char_decode u_dec (
    .ch     (rx_char),
    .ebcdic (ebcdic_sel),
    .cls    (dec_cls)
  );

  bsc_frame_fsm #(.BCC_LEN(BCC_LEN)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rx_valid),
    .in_cls   (dec_cls),
    .vd       (vd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid       <= 1'b0;
      o_char        <= '0;
      o_class       <= '0;
      o_crc_en      <= 1'b0;
      o_discard     <= 1'b0;
      o_frame_start <= 1'b0;
      o_frame_end   <= 1'b0;
      o_check       <= 1'b0;
      o_transparent <= 1'b0;
    end else begin
      o_valid       <= rx_valid;
      o_char        <= rx_valid ? rx_char : '0;
      o_class       <= rx_valid ? vd.cls : CL_DATA;
      o_crc_en      <= vd.crc;
      o_discard     <= vd.disc;
      o_frame_start <= vd.start;
      o_frame_end   <= vd.fin;
      o_check       <= vd.chk;
      o_transparent <= vd.trans;
    end
  end

  p_start_excluded_r4: assert property (@(posedge clk) disable iff (rst)
    o_frame_start |-> !o_crc_en);
  p_end_counted_r9: assert property (@(posedge clk) disable iff (rst)
    o_frame_end |-> o_crc_en);
  p_check_excluded_r10: assert property (@(posedge clk) disable iff (rst)
    o_check |-> (!o_crc_en && !o_transparent));
  p_discard_excluded_r5: assert property (@(posedge clk) disable iff (rst)
    o_discard |-> !o_crc_en);
  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> !(o_crc_en || o_discard || o_frame_start || o_frame_end || o_check));
  p_echo_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (o_valid && o_char == $past(rx_char)));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({o_frame_start, o_frame_end, o_check}));
endmodule

// File: tb/sim_bsc_ctrl_detect.sv
module sim_bsc_ctrl_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ebcdic_sel = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       o_valid, o_crc_en, o_discard, o_frame_start, o_frame_end, o_check, o_transparent;
  logic [7:0] o_char;
  logic [3:0] o_class;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] K_DAT = 4'd0, K_SOH = 4'd1, K_STX = 4'd2, K_ETX = 4'd3,
                         K_EOT = 4'd4, K_ENQ = 4'd5, K_DLE = 4'd6, K_SYN = 4'd7,
                         K_ETB = 4'd8, K_ITB = 4'd9, K_BCC = 4'd10;
  localparam logic [5:0] C = 6'b100000, D = 6'b010000, S = 6'b001000,
                         E = 6'b000100, K = 6'b000010, T = 6'b000001;

  always #5 clk = ~clk;

  bsc_ctrl_detect u0 (
    .clk(clk), .rst(rst), .ebcdic_sel(ebcdic_sel), .rx_valid(rx_valid), .rx_char(rx_char),
    .o_valid(o_valid), .o_char(o_char), .o_class(o_class), .o_crc_en(o_crc_en),
    .o_discard(o_discard), .o_frame_start(o_frame_start), .o_frame_end(o_frame_end),
    .o_check(o_check), .o_transparent(o_transparent)
  );

  function automatic logic [18:0] snap();
    return {o_valid, o_class, o_crc_en, o_discard, o_frame_start, o_frame_end,
            o_check, o_transparent, o_char};
  endfunction

  task automatic cmp(input logic [18:0] exp, input string req);
    logic [18:0] act;
    act = snap();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic put(input logic [7:0] ch, input logic [3:0] cls, input logic [5:0] fl,
                     input string req);
    rx_valid = 1'b1;
    rx_char  = ch;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_char  = 8'h00;
    cmp({1'b1, cls, fl, ch}, req);
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    cmp(19'h0, req);
  endtask

  task automatic do_reset(input logic sel);
    rst = 1'b1;
    ebcdic_sel = sel;
    repeat (3) @(negedge clk);
    cmp(19'h0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    cmp(19'h0, "R1 after reset");
  endtask

  task automatic t_ascii_decode();
    do_reset(1'b0);
    put(8'h16, K_SYN, 6'h0, "R2 ascii SYN");
    put(8'h05, K_ENQ, 6'h0, "R2 ascii ENQ");
    put(8'h04, K_EOT, 6'h0, "R2 ascii EOT");
    put(8'h10, K_DLE, 6'h0, "R2 ascii DLE");
    put(8'h17, K_ETB, 6'h0, "R2 ascii ETB idle");
    put(8'h1F, K_ITB, 6'h0, "R2 ascii ITB idle");
    put(8'h03, K_ETX, 6'h0, "R4 ascii ETX idle");
    put(8'h41, K_DAT, 6'h0, "R4 idle data");
    quiet("R3 no input");
    put(8'h01, K_SOH, S, "R4 SOH start");
    put(8'h02, K_STX, C, "R5 STX in text counted");
    put(8'h03, K_ETX, C | E, "R9 ETX ends");
    put(8'hAA, K_BCC, K, "R10 bcc1");
    put(8'h03, K_BCC, K, "R10 bcc2");
    put(8'h42, K_DAT, 6'h0, "R10 back to idle");
  endtask

  task automatic t_normal_text();
    do_reset(1'b0);
    put(8'h02, K_STX, S, "R4 STX start");
    put(8'h41, K_DAT, C, "R5 data");
    put(8'h16, K_SYN, D, "R5 SYN stripped");
    put(8'h01, K_SOH, C, "R5 SOH in text");
    put(8'h17, K_ETB, C | E, "R9 ETB ends");
    put(8'h17, K_BCC, K, "R10 bcc1");
    quiet("R3 gap in bcc");
    put(8'h16, K_BCC, K, "R10 bcc2");
    put(8'h16, K_SYN, 6'h0, "R4 idle SYN");
  endtask

  task automatic t_transparent();
    do_reset(1'b0);
    put(8'h10, K_DLE, 6'h0, "R6 leading DLE");
    put(8'h02, K_STX, S | T, "R6 DLE STX");
    put(8'h03, K_DAT, C | T, "R7 bare ETX is data");
    put(8'h16, K_DAT, C | T, "R7 bare SYN is data");
    put(8'h10, K_DLE, D | T, "R7 DLE dropped");
    put(8'h10, K_DAT, C | T, "R7 DLE DLE data");
    put(8'h10, K_DLE, D | T, "R8 DLE dropped");
    put(8'h16, K_SYN, D | T, "R8 DLE SYN stripped");
    put(8'h10, K_DLE, D | T, "R7 DLE dropped");
    put(8'h01, K_DAT, C | T, "R7 DLE SOH data");
    put(8'h10, K_DLE, D | T, "R9 DLE dropped");
    put(8'h03, K_ETX, C | E | T, "R9 DLE ETX ends");
    put(8'h10, K_BCC, K, "R10 bcc1");
    put(8'h02, K_BCC, K, "R10 bcc2");
    put(8'h03, K_ETX, 6'h0, "R6 transparent left");
  endtask

  task automatic t_text_escape();
    do_reset(1'b0);
    put(8'h01, K_SOH, S, "R4 SOH");
    put(8'h10, K_DLE, 6'h0, "R11 DLE excluded");
    put(8'h41, K_DAT, C, "R11 data after DLE");
    put(8'h10, K_DLE, 6'h0, "R11 DLE excluded");
    put(8'h02, K_STX, T, "R11 DLE STX mid text");
    put(8'h03, K_DAT, C | T, "R7 bare ETX data");
    put(8'h10, K_DLE, D | T, "R7 DLE dropped");
    put(8'h1F, K_ITB, C | E | T, "R9 DLE ITB ends");
    put(8'h00, K_BCC, K, "R10 bcc1");
    put(8'h00, K_BCC, K, "R10 bcc2");
  endtask

  task automatic t_ebcdic();
    do_reset(1'b1);
    put(8'h32, K_SYN, 6'h0, "R2 ebcdic SYN");
    put(8'h2D, K_ENQ, 6'h0, "R2 ebcdic ENQ");
    put(8'h37, K_EOT, 6'h0, "R2 ebcdic EOT");
    put(8'h16, K_DAT, 6'h0, "R2 ascii SYN is data");
    put(8'h26, K_ETB, 6'h0, "R2 ebcdic ETB");
    put(8'h1F, K_ITB, 6'h0, "R2 ebcdic ITB");
    put(8'h10, K_DLE, 6'h0, "R2 ebcdic DLE");
    put(8'h02, K_STX, S | T, "R6 ebcdic DLE STX");
    put(8'h26, K_DAT, C | T, "R7 bare ETB data");
    put(8'h10, K_DLE, D | T, "R8 DLE");
    put(8'h32, K_SYN, D | T, "R8 ebcdic DLE SYN");
    put(8'h10, K_DLE, D | T, "R9 DLE");
    put(8'h26, K_ETB, C | E | T, "R9 ebcdic DLE ETB");
    put(8'h11, K_BCC, K, "R10 bcc1");
    put(8'h22, K_BCC, K, "R10 bcc2");
    put(8'h01, K_SOH, S, "R4 next frame");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_ascii_decode();
    t_normal_text();
    t_transparent();
    t_text_escape();
    t_ebcdic();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule